// File: doc/BRIEF.md
# Two-stage latched serial-to-parallel register

This block turns a serial bit stream into a parallel word in two steps. A shift stage takes one bit from a serial data pin on every rising edge of a shift strobe. A second, independent strobe copies the whole shift stage into a holding register, and that holding register drives the parallel output bus. Because the bus only changes on the copy strobe, a word can be assembled bit by bit while the outputs stay steady.

Both strobes, the serial data bit and the active-low clear reach the block as plain levels. They are brought into the single system clock domain through two-flop synchronisers, and each strobe goes through a rising-edge detector. The active-low clear empties the shift stage only. An active-low output enable chooses between showing the holding register and releasing the bus. A release is modelled as a low `par_valid` and an all-zero data bus, so the core needs no internal tri-states.

A serial output shows the last shift bit. Connecting it to the serial input of a second unit that shares both strobes makes a longer chain.

Top module: `latched_sipo`

## Requirements
- R1: After system reset, the shift stage and the holding register are all zero. With `oe_n` low, `par_data` reads 0, `par_valid` reads 1 and `ser_out` reads 0.
- R2: On each detected rising edge of `shift_clk` with the clear inactive, bit 0 of the shift stage takes `ser_in`, and bit n takes the old bit n-1. With no edge the shift stage holds. The first bit of eight shifted bits ends in bit 7.
- R3: On each detected rising edge of `store_clk`, the holding register takes the shift stage. At all other times it holds its value.
- R4: While `clr_n` is low, the shift stage is forced to zero, and shift edges have no effect.
- R5: The clear leaves the holding register unchanged while no store edge occurs.
- R6: With `oe_n` high, `par_valid` is 0 and `par_data` is 0. With `oe_n` low, `par_valid` is 1 and `par_data` equals the holding register, with bit i of the bus being shift bit i.
- R7: `ser_out` always equals bit 7 (the top bit) of the shift stage, so a second unit fed from it and sharing both strobes receives the bits pushed out of the first.
- R8: When a shift edge and a store edge are detected in the same cycle, the holding register takes the shift stage as it was before that shift.
- R9: A store edge that arrives while the clear is active loads zero into the holding register.
- R10: A strobe held high for many cycles causes exactly one shift or one store. A new action needs the strobe to go low and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit |
| shift_clk | input | 1 | Shift strobe; a rising edge shifts |
| store_clk | input | 1 | Store strobe; a rising edge copies the shift stage |
| clr_n | input | 1 | Active-low clear of the shift stage |
| oe_n | input | 1 | Active-low output enable |
| par_data | output | 8 | Parallel word, zero when released |
| par_valid | output | 1 | High when the bus is driven |
| ser_out | output | 1 | Top shift bit, used for chaining |

## Verification
On every cycle, the assertions check the following:
- The shift-stage motion on an edge, and its stability without one.
- Emptying under clear.
- Stability of the holding register away from store edges.
- Which value a store edge captures, including the pre-shift value when both edges coincide and the zero during clear.
- The single-cycle width of each detected edge.

Only the bench scenarios can show the following:
- The full mapping from a serial bit sequence to the parallel word.
- The two-unit chain carrying sixteen bits correctly.
- The output-enable release.
- That a long strobe causes only one action.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    localparam int SIPO_W      = 8;
    localparam int SYNC_DEPTH  = 2;

    // Per-cycle events seen by the two storage stages
    typedef struct packed {
        logic shift;   // rising edge of the shift strobe
        logic store;   // rising edge of the store strobe
        logic clear;   // clear active (already synchronised)
        logic din;     // synchronised serial bit
    } sipo_evt_t;

    typedef enum logic [1:0] {
        HOLD_ACT = 2'd0,
        COPY_ACT = 2'd1,
        ZERO_ACT = 2'd2
    } store_act_t;

    function automatic store_act_t pick_store_act(sipo_evt_t ev);
        if (!ev.store)      return HOLD_ACT;
        else if (ev.clear)  return ZERO_ACT;
        else                return COPY_ACT;
    endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int   DEPTH   = sipo_pkg::SYNC_DEPTH,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= {DEPTH{RST_VAL}};
        else     stg <= {stg[DEPTH-2:0], din};
    end

    assign dout = stg[DEPTH-1];

    initial begin
        AST_DEPTH_OK: assert (DEPTH >= 2); // R10
    end
endmodule

// File: rtl/edge_detect.sv
module edge_detect #(
    parameter int DEPTH = sipo_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);
    logic lvl;
    logic lvl_q;

    sync_chain #(.DEPTH(DEPTH), .RST_VAL(1'b0)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (strobe),
        .dout(lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R10
endmodule

// File: rtl/shift_stage.sv
module shift_stage
    import sipo_pkg::*;
#(
    parameter int WIDTH = SIPO_W
) (
    input  logic             clk,
    input  logic             rst,
    input  sipo_evt_t        ev,
    output logic [WIDTH-1:0] bits
);
    logic [WIDTH-1:0] nxt;

    always_comb begin
        nxt = bits;
        if (ev.clear)      nxt = '0;
        else if (ev.shift) nxt = {bits[WIDTH-2:0], ev.din};
    end

    always_ff @(posedge clk) begin
        if (rst) bits <= '0;
        else     bits <= nxt;
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        ev.clear |=> (bits == '0)); // R4
    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
        (ev.shift && !ev.clear) |=>
            (bits[WIDTH-1:1] == $past(bits[WIDTH-2:0])) && (bits[0] == $past(ev.din))); // R2
    AST_SHIFT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ev.shift && !ev.clear) |=> $stable(bits)); // R2
endmodule

// File: rtl/store_stage.sv
module store_stage
    import sipo_pkg::*;
#(
    parameter int WIDTH = SIPO_W
) (
    input  logic             clk,
    input  logic             rst,
    input  sipo_evt_t        ev,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] held
);
    store_act_t act;

    assign act = pick_store_act(ev);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else begin
            unique case (act)
                COPY_ACT: held <= src;
                ZERO_ACT: held <= '0;
                default:  held <= held;
            endcase
        end
    end

    AST_STORE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ev.store |=> $stable(held)); // R3
    AST_STORE_COPY: assert property (@(posedge clk) disable iff (rst)
        (ev.store && !ev.clear) |=> (held == $past(src))); // R8
    AST_STORE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (ev.store && ev.clear) |=> (held == '0)); // R9
endmodule

// File: rtl/latched_sipo.sv
module latched_sipo
    import sipo_pkg::*;
#(
    parameter int WIDTH = SIPO_W,
    parameter int DEPTH = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    input  logic             shift_clk,
    input  logic             store_clk,
    input  logic             clr_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] par_data,
    output logic             par_valid,
    output logic             ser_out
);
    sipo_evt_t        ev;
    logic             shift_rise;
    logic             store_rise;
    logic             din_s;
    logic             clr_n_s;
    logic [WIDTH-1:0] sh_bits;
    logic [WIDTH-1:0] st_bits;

    edge_detect #(.DEPTH(DEPTH)) u_shift_edge (
        .clk(clk), .rst(rst), .strobe(shift_clk), .rise(shift_rise)
    );
    edge_detect #(.DEPTH(DEPTH)) u_store_edge (
        .clk(clk), .rst(rst), .strobe(store_clk), .rise(store_rise)
    );
    sync_chain #(.DEPTH(DEPTH), .RST_VAL(1'b0)) u_din_sync (
        .clk(clk), .rst(rst), .din(ser_in), .dout(din_s)
    );
    sync_chain #(.DEPTH(DEPTH), .RST_VAL(1'b1)) u_clr_sync (
        .clk(clk), .rst(rst), .din(clr_n), .dout(clr_n_s)
    );

    always_comb begin
        ev.shift = shift_rise;
        ev.store = store_rise;
        ev.clear = ~clr_n_s;
        ev.din   = din_s;
    end

    shift_stage #(.WIDTH(WIDTH)) u_shift (
        .clk(clk), .rst(rst), .ev(ev), .bits(sh_bits)
    );
    store_stage #(.WIDTH(WIDTH)) u_store (
        .clk(clk), .rst(rst), .ev(ev), .src(sh_bits), .held(st_bits)
    );

    assign par_valid = ~oe_n;
    assign par_data  = oe_n ? '0 : st_bits;
    assign ser_out   = sh_bits[WIDTH-1];

    AST_CLEAR_KEEPS_STORE: assert property (@(posedge clk) disable iff (rst)
        (ev.clear && !ev.store) |=> $stable(st_bits)); // R5
    AST_RELEASED_BUS: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (par_data == '0) && !par_valid); // R6
    AST_RESET_EMPTY: assert property (@(posedge clk)
        $past(rst) |-> (sh_bits == '0) && (st_bits == '0)); // R1
endmodule

// File: tb/tb_latched_sipo.sv
module tb_latched_sipo;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic       shift_clk = 1'b0;
    logic       store_clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       oe_n = 1'b0;
    logic [7:0] pa, pb;
    logic       va, vb;
    logic       so_a, so_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 8 ns period

    latched_sipo dut (
        .clk(clk), .rst(rst), .ser_in(ser_in), .shift_clk(shift_clk),
        .store_clk(store_clk), .clr_n(clr_n), .oe_n(oe_n),
        .par_data(pa), .par_valid(va), .ser_out(so_a)
    );
    latched_sipo dut_b (
        .clk(clk), .rst(rst), .ser_in(so_a), .shift_clk(shift_clk),
        .store_clk(store_clk), .clr_n(clr_n), .oe_n(oe_n),
        .par_data(pb), .par_valid(vb), .ser_out(so_b)
    );

    // {stimulus byte, oe_n, expected bus, expected valid}
    localparam logic [17:0] VEC [6] = '{
        {8'hA5, 1'b0, 8'hA5, 1'b1},
        {8'h3C, 1'b0, 8'h3C, 1'b1},
        {8'hFF, 1'b1, 8'h00, 1'b0},
        {8'h01, 1'b0, 8'h01, 1'b1},
        {8'h80, 1'b1, 8'h00, 1'b0},
        {8'h6E, 1'b0, 8'h6E, 1'b1}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        ser_in = b;
        shift_clk = 1'b1; tick(4);
        shift_clk = 1'b0; tick(4);
    endtask

    task automatic store_pulse();
        store_clk = 1'b1; tick(4);
        store_clk = 1'b0; tick(4);
    endtask

    task automatic shift_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) shift_bit(v[i]);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(2);
        // R1 reset state
        check("R1 bus", {7'd0, va, pa}, {7'd0, 1'b1, 8'h00});
        check("R1 ser_out", {15'd0, so_a}, 16'd0);

        // R2 R3 R6 R7 table of patterns
        for (int k = 0; k < 6; k++) begin
            oe_n = 1'b0;
            shift_byte(VEC[k][17:10]);
            check("R7 ser_out", {15'd0, so_a}, {15'd0, VEC[k][17]});
            store_pulse();
            oe_n = VEC[k][9];
            tick(1);
            check("R2/R3/R6 bus", {7'd0, va, pa}, {7'd0, VEC[k][0], VEC[k][8:1]});
        end
        oe_n = 1'b0;
        tick(1);

        // R7 chain of two: 16 bits, upper byte lands in second unit
        for (int i = 15; i >= 0; i--) shift_bit(logic'(16'hC3A6 >> i));
        store_pulse();
        check("R7 chain", {pb, pa}, 16'hC3A6);
        check("R7 second ser_out", {15'd0, so_b}, 16'd1);

        // R3 shift without store leaves bus alone
        shift_bit(1'b0);
        check("R3 hold", {8'd0, pa}, 16'h00A6);

        // R4 R5: clear empties shift stage, keeps store
        clr_n = 1'b0; tick(4);
        shift_bit(1'b1);
        check("R5 store kept", {8'd0, pa}, 16'h00A6);
        clr_n = 1'b1; tick(4);
        check("R4 ser_out zero", {15'd0, so_a}, 16'd0);
        store_pulse();
        check("R4 cleared then stored", {8'd0, pa}, 16'h0000);

        // R9 store during clear loads zero
        shift_byte(8'h5A);
        store_pulse();
        check("R9 setup", {8'd0, pa}, 16'h005A);
        clr_n = 1'b0; tick(4);
        store_pulse();
        check("R9 store under clear", {8'd0, pa}, 16'h0000);
        clr_n = 1'b1; tick(4);

        // R8 simultaneous edges: store takes pre-shift value
        shift_byte(8'h4B);
        ser_in = 1'b1;
        shift_clk = 1'b1; store_clk = 1'b1; tick(4);
        shift_clk = 1'b0; store_clk = 1'b0; tick(4);
        check("R8 pre-shift", {8'd0, pa}, 16'h004B);
        store_pulse();
        check("R8 after shift", {8'd0, pa}, 16'h0097);

        // R10 long strobe shifts once
        clr_n = 1'b0; tick(4); clr_n = 1'b1; tick(4);
        ser_in = 1'b1;
        shift_clk = 1'b1; tick(30);
        shift_clk = 1'b0; tick(4);
        store_clk = 1'b1; tick(30);
        store_clk = 1'b0; tick(4);
        check("R10 single shift", {8'd0, pa}, 16'h0001);

        // R1 reset again clears store
        rst = 1'b1; tick(2); rst = 1'b0; tick(2);
        check("R1 re-reset", {8'd0, pa}, 16'h0000);

        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule